// File: doc/BRIEF.md
# Buffered Timekeeping Register File

This block holds the byte-addressed register space of a battery-backed real-time clock. A serial-bus engine reports bus events to it: start, stop, each received byte at its acknowledge, and each read request. The block keeps a 6-bit register pointer that steps through a 64-byte map. Bytes 0 to 6 are the time and date fields, byte 7 is the control byte, and bytes 8 to 63 are 56 bytes of general-purpose RAM.

Reads of the time fields are not taken from the running counter. They come from a local snapshot, so a burst that reads several fields sees one consistent instant even if the counter rolls over during the burst. The snapshot is refreshed in three cases only: at a bus start, at a bus stop, and when the pointer wraps to zero. Writes to the time fields go straight to the counter through a strobe in the same cycle as the acknowledge. A write to the seconds field also restarts the counter's sub-second divider.

Top module: `rtc_regfile`

## Requirements
- R1: After reset `rdValid` is 0, `sqwEnable`, `rateSel` and `outLevel` are 0, and the control byte reads 0x20, which means the oscillator-fail flag is set.
- R2: In a transaction started with `busRead`=0, the first acknowledged byte loads the pointer from its bits 5:0 and produces no write strobe.
- R3: The pointer advances by one after every data byte written or read, and it wraps from 0x3F to 0x00.
- R4: `rdData` presents the byte at the pointer, with `rdValid` high, in the cycle after a `rdReq` pulse.
- R5: Addresses 0x00 to 0x06 read from a snapshot of `liveTime`, where byte n sits at bits 8n+7:8n. The snapshot is taken only on `busStart`, on `busStop`, or when a data access wraps the pointer to 0x00. Any later change of `liveTime` does not show until the next snapshot.
- R6: Reserved bits read as 0:
  - bit 7 of 0x01 and 0x02;
  - bits 7:3 of 0x03;
  - bits 7:6 of 0x04;
  - bits 7:5 of 0x05;
  - bits 6, 3 and 2 of the control byte 0x07.
- R7: A data byte acknowledged at address 0x00 to 0x06 raises `timeWrEn` in that same cycle, with `timeWrAddr` equal to the address and `timeWrData` equal to the byte.
- R8: `chainReset` is high in the acknowledge cycle of a data write to 0x00, and low otherwise.
- R9: A write to 0x07 sets the following, and the byte reads back the same way:
  - `outLevel` from bit 7;
  - `sqwEnable` from bit 4;
  - `rateSel` from bits 1:0.
- R10: The oscillator-fail flag at bit 5 of 0x07 works as follows:
  - writing 0 clears it;
  - writing 1 leaves it unchanged;
  - an `oscFail` pulse sets it.
- R11: Addresses 0x08 to 0x3F store and return written bytes, and writes there or to 0x07 never raise `timeWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Start condition pulse |
| busStop | input | 1 | Stop condition pulse |
| busRead | input | 1 | Direction of the transaction, sampled with `busStart` (1 = read) |
| byteAck | input | 1 | A received byte is being acknowledged |
| wrByte | input | 8 | Received byte, valid with `byteAck` |
| rdReq | input | 1 | The bus needs the next read byte |
| liveTime | input | 56 | Running time fields from the counter, seven bytes |
| oscFail | input | 1 | Oscillator stop detected, sets the fail flag |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | `rdData` holds a fresh byte |
| timeWrEn | output | 1 | Write strobe to a counter field |
| timeWrAddr | output | 3 | Counter field index |
| timeWrData | output | 8 | Counter field value |
| chainReset | output | 1 | Restart the sub-second divider |
| sqwEnable | output | 1 | Square-wave output enable |
| rateSel | output | 2 | Square-wave rate select |
| outLevel | output | 1 | Static output level when the square wave is off |

## Verification
The hardest case is the snapshot refresh caused by pointer wrap inside a single read burst. No start or stop may occur between the read of 0x3F and the read of 0x00, and the counter value must change during the burst. The stimulus therefore reads the whole RAM in one transaction. It changes `liveTime` between the reads of 0x3E and 0x3F, then reads address 0x00 and expects the new seconds value rather than the value captured at the start.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int AW = 6;
  localparam int NTIME = 7;
  localparam int MAPSIZE = 1 << AW;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(7);
  localparam logic [AW-1:0] RAM_BASE = AW'(8);
  localparam logic [AW-1:0] LAST_ADDR = '1;
  localparam int RAMDEPTH = MAPSIZE - 8;

  typedef struct packed {
    logic snapLoad;
    logic wrEn;
    logic rdEn;
    logic [AW-1:0] addr;
  } strobe_t;
endpackage

// File: rtl/rtc_regfile_ctrl.sv
module rtc_regfile_ctrl
  import rtc_regfile_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busStart,
  input  logic busStop,
  input  logic busRead,
  input  logic byteAck,
  input  logic [AW-1:0] ptrLoad,
  input  logic rdReq,
  output strobe_t strb
);
  logic [AW-1:0] ptr;
  logic needAddr;
  logic inWrite;
  logic addrWr;
  logic dataWr;

  assign addrWr = byteAck && needAddr;
  assign dataWr = byteAck && !needAddr && inWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      needAddr <= 1'b0;
      inWrite <= 1'b0;
    end else if (busStart) begin
      needAddr <= !busRead;
      inWrite <= !busRead;
    end else if (busStop) begin
      needAddr <= 1'b0;
      inWrite <= 1'b0;
    end else if (addrWr) begin
      ptr <= ptrLoad;
      needAddr <= 1'b0;
    end else if (dataWr || rdReq) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    strb.addr = ptr;
    strb.wrEn = dataWr;
    strb.rdEn = rdReq;
    strb.snapLoad = busStart || busStop || ((dataWr || rdReq) && ptr == LAST_ADDR);
  end

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrWr && !busStart && !busStop) |=> ptr == $past(ptrLoad));
  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !busStart && !busStop && strb.addr == LAST_ADDR) |=> ptr == '0);
endmodule

// File: rtl/rtc_regfile_dp.sv
module rtc_regfile_dp
  import rtc_regfile_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [7:0] wrByte,
  input  logic [8*NTIME-1:0] liveTime,
  input  logic oscFail,
  output logic [7:0] rdData,
  output logic rdValid,
  output logic timeWrEn,
  output logic [2:0] timeWrAddr,
  output logic [7:0] timeWrData,
  output logic chainReset,
  output logic sqwEnable,
  output logic [1:0] rateSel,
  output logic outLevel
);
  logic [7:0] snap [NTIME];
  logic [7:0] ram [RAMDEPTH];
  logic [AW-1:0] ramIdx;
  logic osfQ;
  logic [7:0] readByte;
  logic isTime;

  function automatic logic [7:0] fieldMask(input logic [AW-1:0] a);
    case (a)
      AW'(1), AW'(2): fieldMask = 8'h7F;
      AW'(3): fieldMask = 8'h07;
      AW'(4): fieldMask = 8'h3F;
      AW'(5): fieldMask = 8'h1F;
      default: fieldMask = 8'hFF;
    endcase
  endfunction

  generate
    for (genvar g = 0; g < NTIME; g++) begin : g_snap
      always_ff @(posedge clk) begin
        if (!rstN) snap[g] <= '0;
        else if (strb.snapLoad) snap[g] <= liveTime[8*g +: 8];
      end
    end
  endgenerate

  assign isTime = strb.addr < CTRL_ADDR;
  assign ramIdx = strb.addr - RAM_BASE;

  always_ff @(posedge clk) begin
    if (strb.wrEn && strb.addr >= RAM_BASE) ram[ramIdx] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      osfQ <= 1'b1;
      sqwEnable <= 1'b0;
      rateSel <= '0;
      outLevel <= 1'b0;
    end else begin
      if (strb.wrEn && strb.addr == CTRL_ADDR) begin
        outLevel <= wrByte[7];
        sqwEnable <= wrByte[4];
        rateSel <= wrByte[1:0];
      end
      if (oscFail) osfQ <= 1'b1;
      else if (strb.wrEn && strb.addr == CTRL_ADDR && !wrByte[5]) osfQ <= 1'b0;
    end
  end

  always_comb begin
    if (isTime) readByte = snap[strb.addr[2:0]] & fieldMask(strb.addr);
    else if (strb.addr == CTRL_ADDR) readByte = {outLevel, 1'b0, osfQ, sqwEnable, 2'b00, rateSel};
    else readByte = ram[ramIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= readByte;
    end
  end

  assign timeWrEn = strb.wrEn && isTime;
  assign timeWrAddr = strb.addr[2:0];
  assign timeWrData = wrByte;
  assign chainReset = strb.wrEn && strb.addr == '0;

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdValid);
  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.snapLoad |=> $stable(snap[0]));
  // R8
  chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainReset |-> (timeWrEn && timeWrAddr == 3'd0));
  // R10
  osf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(osfQ) |-> $past(oscFail));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busStart,
  input  logic busStop,
  input  logic busRead,
  input  logic byteAck,
  input  logic [7:0] wrByte,
  input  logic rdReq,
  input  logic [55:0] liveTime,
  input  logic oscFail,
  output logic [7:0] rdData,
  output logic rdValid,
  output logic timeWrEn,
  output logic [2:0] timeWrAddr,
  output logic [7:0] timeWrData,
  output logic chainReset,
  output logic sqwEnable,
  output logic [1:0] rateSel,
  output logic outLevel
);
  strobe_t strb;

  rtc_regfile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .busRead(busRead), .byteAck(byteAck), .ptrLoad(wrByte[AW-1:0]),
    .rdReq(rdReq), .strb(strb)
  );

  rtc_regfile_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte),
    .liveTime(liveTime), .oscFail(oscFail), .rdData(rdData),
    .rdValid(rdValid), .timeWrEn(timeWrEn), .timeWrAddr(timeWrAddr),
    .timeWrData(timeWrData), .chainReset(chainReset),
    .sqwEnable(sqwEnable), .rateSel(rateSel), .outLevel(outLevel)
  );
endmodule

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStart = 1'b0, busStop = 1'b0, busRead = 1'b0, byteAck = 1'b0;
  logic rdReq = 1'b0, oscFail = 1'b0;
  logic [7:0] wrByte = '0;
  logic [55:0] liveTime = '0;
  logic [7:0] rdData, timeWrData;
  logic rdValid, timeWrEn, chainReset, sqwEnable, outLevel;
  logic [2:0] timeWrAddr;
  logic [1:0] rateSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  rtc_regfile u_rtc_regfile (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: compares read bytes with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R4 unexpected rdValid", 8'h01, 8'h00);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic startX(input logic rd);
    busRead = rd; busStart = 1'b1; @(negedge clk); busStart = 1'b0;
  endtask
  task automatic stopX;
    busStop = 1'b1; @(negedge clk); busStop = 1'b0;
  endtask
  task automatic ackChk(input logic [7:0] b, input logic expWr, input logic [2:0] expA,
                        input logic expChain, input string tag);
    wrByte = b; byteAck = 1'b1; #1;
    check({tag, " timeWrEn"}, {7'd0, timeWrEn}, {7'd0, expWr});
    check({tag, " chainReset"}, {7'd0, chainReset}, {7'd0, expChain});
    if (expWr) begin
      check({tag, " timeWrAddr"}, {5'd0, timeWrAddr}, {5'd0, expA});
      check({tag, " timeWrData"}, timeWrData, b);
    end
    @(negedge clk); byteAck = 1'b0;
  endtask
  task automatic rdPush(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
  endtask
  task automatic setPtr(input logic [7:0] a);
    startX(1'b0); ackChk(a, 1'b0, 3'd0, 1'b0, "R2 address byte"); stopX();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rdValid", {7'd0, rdValid}, 8'd0);
    check("R1 sqwEnable", {7'd0, sqwEnable}, 8'd0);
    check("R1 rateSel", {6'd0, rateSel}, 8'd0);
    check("R1 outLevel", {7'd0, outLevel}, 8'd0);
    setPtr(8'h07);
    startX(1'b1); rdPush(8'h20, "R1 control after reset"); stopX();

    // R5 snapshot at start, R6 reserved bits masked
    liveTime = {7{8'hFF}};
    setPtr(8'h00);
    startX(1'b1);
    liveTime = '0;
    rdPush(8'hFF, "R5 seconds from snapshot");
    rdPush(8'h7F, "R6 minutes mask");
    rdPush(8'h7F, "R6 hours mask");
    rdPush(8'h07, "R6 day mask");
    rdPush(8'h3F, "R6 date mask");
    rdPush(8'h1F, "R6 month mask");
    rdPush(8'hFF, "R5 year from snapshot");
    rdPush(8'h20, "R3 pointer reaches control");
    stopX();

    // R7 R8 time writes
    startX(1'b0);
    ackChk(8'h00, 1'b0, 3'd0, 1'b0, "R2 no strobe on address");
    ackChk(8'h45, 1'b1, 3'd0, 1'b1, "R8 seconds write");
    ackChk(8'h12, 1'b1, 3'd1, 1'b0, "R7 minutes write");
    ackChk(8'h03, 1'b1, 3'd2, 1'b0, "R7 hours write");
    stopX();

    // R9 R10 control
    startX(1'b0);
    ackChk(8'h07, 1'b0, 3'd0, 1'b0, "R2 address byte");
    ackChk(8'h93, 1'b0, 3'd0, 1'b0, "R11 control write no strobe");
    stopX();
    check("R9 outLevel", {7'd0, outLevel}, 8'd1);
    check("R9 sqwEnable", {7'd0, sqwEnable}, 8'd1);
    check("R9 rateSel", {6'd0, rateSel}, 8'd3);
    setPtr(8'h07);
    startX(1'b1); rdPush(8'h93, "R9 R10 control readback, flag cleared"); stopX();
    startX(1'b0);
    ackChk(8'h07, 1'b0, 3'd0, 1'b0, "R2 address byte");
    ackChk(8'hFF, 1'b0, 3'd0, 1'b0, "R11 control write no strobe");
    stopX();
    setPtr(8'h07);
    startX(1'b1); rdPush(8'h93, "R10 write 1 does not set flag, R6 reserved"); stopX();
    oscFail = 1'b1; @(negedge clk); oscFail = 1'b0;
    setPtr(8'h07);
    startX(1'b1); rdPush(8'hB3, "R10 oscFail sets flag"); stopX();

    // R11 RAM fill, R3 wrap on write
    startX(1'b0);
    ackChk(8'h08, 1'b0, 3'd0, 1'b0, "R2 address byte");
    for (int i = 0; i < 56; i++)
      ackChk(8'(i * 7 + 3), 1'b0, 3'd0, 1'b0, "R11 RAM write no strobe");
    ackChk(8'h59, 1'b1, 3'd0, 1'b1, "R3 write wraps to seconds");
    stopX();

    // R11 RAM read, R5 refresh on wrap inside one read burst
    liveTime = {48'd0, 8'h11};
    setPtr(8'h08);
    startX(1'b1);
    for (int i = 0; i < 56; i++) begin
      if (i == 55) liveTime = {48'd0, 8'h22};
      rdPush(8'(i * 7 + 3), "R11 RAM readback");
    end
    rdPush(8'h22, "R5 snapshot refreshed on pointer wrap");
    rdPush(8'h00, "R3 pointer continues after wrap");
    stopX();

    repeat (3) @(negedge clk);
    check("R4 all reads returned", 8'(expQ.size()), 8'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual hung expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule